// File: doc/BRIEF.md
# Handshaked Parallel Block Receiver

This block takes a block of bytes from a neighbouring device over an 8-bit parallel bus. Each transfer uses one strobe wire in each direction. The peer places a byte on the bus and raises its valid line. The receiver takes the byte, writes it into a data memory through a single write port, and answers with an acknowledge pulse of fixed length. The peer then drops valid and presents the next byte. Right after reset, the receiver sends a short acknowledge pulse by itself. This pulse tells the peer that the receiver is listening.

The first byte of a block is a length. It is written unchanged to a fixed header location. The data bytes that follow go to two independent regions in turn, and each region has its own address pointer that advances after every use. When the expected number of data bytes has arrived, the receiver raises a done flag and ignores the bus until the next reset. The valid line is asynchronous to the local clock and passes through a synchronizer. One byte is taken per valid pulse, however long the peer holds the line high.

Top module: `byte_block_rx`

## Requirements
- R1: While reset is asserted, ackOut, memWe and done are 0. In the first cycle after reset is released ackOut is 0, in the second it is 1, and from the third it stays 0 until a byte is taken.
- R2: peerValid passes through a two-stage synchronizer. When the receiver is idle and re-armed and peerValid rises, memWe goes high on the third rising clock edge after the change and not before.
- R3: At most one byte is taken per high period of peerValid. While peerValid stays high after the acknowledge, there are no further writes and no further acknowledges.
- R4: Each byte taken produces exactly one write cycle, with memWe high for one clock. memData carries the bus value that was present when the byte was taken.
- R5: Starting in the cycle after each write, ackOut is high for exactly ACK_HOLD consecutive cycles (default 2) and then returns low.
- R6: The first byte after reset is written unmodified to address 0x20.
- R7: Data bytes go alternately to region A and region B. Region A starts at 0x31 and region B starts at 0x61, and the first data byte goes to region A. Each region's pointer increases by one after every write to that region, so data byte i (counting from 0) goes to 0x31+i/2 when i is even and to 0x61+i/2 when i is odd.
- R8: The number of data bytes taken is the length byte's value, limited to MAX_DATA (default 60). A length of 0 takes no data bytes at all.
- R9: done rises in the cycle in which the acknowledge of the final byte falls, and it stays high until reset. While done is high, valid pulses produce no write and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busData | input | 8 | Parallel byte from the peer |
| peerValid | input | 1 | Peer's byte-present strobe (asynchronous) |
| ackOut | output | 1 | Acknowledge and ready strobe to the peer |
| memWe | output | 1 | Data memory write enable |
| memAddr | output | 8 | Data memory write address |
| memData | output | 8 | Data memory write data |
| done | output | 1 | Block complete, sticky until reset |

## Verification
Two situations are the hardest to reach from the ports. The first is a peer that keeps valid high long after the acknowledge has ended, which must not yield a second byte. The second is a length byte larger than the limit, where the receiver must stop early and then stay silent while the peer keeps offering bytes. The stimulus covers these cases with a directed held-valid transfer placed inside otherwise random blocks, plus blocks with lengths 61 and 200 that are followed by extra valid pulses after done. Random blocks with random lengths, data and peer gap times exercise the ping-pong addressing, with zero, one and maximum lengths added as directed cases.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef struct packed {
    logic capture;
    logic store;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_RDY_LO,
    ST_RDY_HI,
    ST_WAIT,
    ST_STORE,
    ST_ACK,
    ST_DONE
  } rxState_t;

endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int ACK_HOLD    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      peerValid,
  input  logic      remZero,
  output rxStrobe_t strobe,
  output logic      ackOut,
  output logic      done
);

  localparam int HOLD_W = (ACK_HOLD > 1) ? $clog2(ACK_HOLD) : 1;

  logic [SYNC_STAGES-1:0] vPipe;
  logic                   vSync;
  logic                   armed;
  logic                   accept;
  logic                   holdLast;
  logic [HOLD_W-1:0]      holdCnt;
  rxState_t               state, nextState;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) vPipe <= '0;
        else       vPipe <= {vPipe[SYNC_STAGES-2:0], peerValid};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) vPipe <= '0;
        else       vPipe <= peerValid;
      end
    end
  endgenerate

  assign vSync    = vPipe[SYNC_STAGES-1];
  assign accept   = (state == ST_WAIT) && vSync && armed;
  assign holdLast = (holdCnt == HOLD_W'(ACK_HOLD - 1));

  // re-arm only after the synchronized strobe has been seen low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       armed <= 1'b1;
    else if (!vSync) armed <= 1'b1;
    else if (accept) armed <= 1'b0;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_RDY_LO: nextState = ST_RDY_HI;
      ST_RDY_HI: nextState = ST_WAIT;
      ST_WAIT:   if (accept) nextState = ST_STORE;
      ST_STORE:  nextState = ST_ACK;
      ST_ACK:    if (holdLast) nextState = remZero ? ST_DONE : ST_WAIT;
      ST_DONE:   nextState = ST_DONE;
      default:   nextState = ST_RDY_LO;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RDY_LO;
    else       state <= nextState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 holdCnt <= '0;
    else if (state == ST_ACK)  holdCnt <= holdCnt + 1'b1;
    else                       holdCnt <= '0;
  end

  assign strobe.capture = accept;
  assign strobe.store   = (state == ST_STORE);
  assign ackOut         = (state == ST_RDY_HI) || (state == ST_ACK);
  assign done           = (state == ST_DONE);

endmodule

// File: rtl/rx_dpath.sv
module rx_dpath
  import rx_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  LEN_ADDR = 8'h20,
  parameter logic [7:0]  BASE_A   = 8'h31,
  parameter logic [7:0]  BASE_B   = 8'h61,
  parameter int          MAX_DATA = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busData,
  input  rxStrobe_t         strobe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              remZero
);

  localparam logic [DATA_W-1:0] MAX_V = DATA_W'(MAX_DATA);

  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] remCnt;
  logic [ADDR_W-1:0] ptrA, ptrB;
  logic              useB;
  logic              haveLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataReg <= '0;
    else if (strobe.capture) dataReg <= busData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveLen <= 1'b0;
      remCnt  <= '0;
      ptrA    <= ADDR_W'(BASE_A);
      ptrB    <= ADDR_W'(BASE_B);
      useB    <= 1'b0;
    end else if (strobe.store) begin
      if (!haveLen) begin
        haveLen <= 1'b1;
        remCnt  <= (dataReg > MAX_V) ? MAX_V : dataReg;
      end else begin
        remCnt <= remCnt - 1'b1;
        useB   <= ~useB;
        if (useB) ptrB <= ptrB + 1'b1;
        else      ptrA <= ptrA + 1'b1;
      end
    end
  end

  assign memWe   = strobe.store;
  assign memData = dataReg;
  assign memAddr = !haveLen ? ADDR_W'(LEN_ADDR) : (useB ? ptrB : ptrA);
  assign remZero = haveLen && (remCnt == '0);

endmodule

// File: rtl/byte_block_rx.sv
module byte_block_rx
  import rx_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  LEN_ADDR    = 8'h20,
  parameter logic [7:0]  BASE_A      = 8'h31,
  parameter logic [7:0]  BASE_B      = 8'h61,
  parameter int          MAX_DATA    = 60,
  parameter int          ACK_HOLD    = 2,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busData,
  input  logic              peerValid,
  output logic              ackOut,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              done
);

  rxStrobe_t strobe;
  logic      remZero;

  rx_ctrl #(
    .ACK_HOLD   (ACK_HOLD),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .peerValid(peerValid),
    .remZero  (remZero),
    .strobe   (strobe),
    .ackOut   (ackOut),
    .done     (done)
  );

  rx_dpath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .LEN_ADDR(LEN_ADDR),
    .BASE_A  (BASE_A),
    .BASE_B  (BASE_B),
    .MAX_DATA(MAX_DATA)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .busData(busData),
    .strobe (strobe),
    .memWe  (memWe),
    .memAddr(memAddr),
    .memData(memData),
    .remZero(remZero)
  );

endmodule

// File: rtl/byte_block_rx_chk.sv
module byte_block_rx_chk #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  LEN_ADDR = 8'h20,
  parameter logic [7:0]  BASE_A   = 8'h31,
  parameter logic [7:0]  BASE_B   = 8'h61,
  parameter int          MAX_DATA = 60,
  parameter int          ACK_HOLD = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              ackOut,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              done
);

  localparam int SPAN_A = (MAX_DATA + 1) / 2;
  localparam int SPAN_B = MAX_DATA / 2;

  int   ackRun;
  logic addrOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ackRun <= 0;
    else if (ackOut) ackRun <= ackRun + 1;
    else             ackRun <= 0;
  end

  assign addrOk = (int'(memAddr) == int'(LEN_ADDR)) ||
                  (int'(memAddr) >= int'(BASE_A) && int'(memAddr) < int'(BASE_A) + SPAN_A) ||
                  (int'(memAddr) >= int'(BASE_B) && int'(memAddr) < int'(BASE_B) + SPAN_B);

  // R4
  wr_single_chk: assert property (@(posedge clk) disable iff (!rstN) memWe |=> !memWe);

  // R5
  ack_after_wr_chk: assert property (@(posedge clk) disable iff (!rstN) memWe |=> ackOut);

  // R5
  ack_len_chk: assert property (@(posedge clk) disable iff (!rstN) ackOut |-> (ackRun < ACK_HOLD));

  // R7
  wr_range_chk: assert property (@(posedge clk) disable iff (!rstN) memWe |-> addrOk);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> (!memWe && !ackOut));

endmodule

bind byte_block_rx byte_block_rx_chk #(
  .ADDR_W  (ADDR_W),
  .LEN_ADDR(LEN_ADDR),
  .BASE_A  (BASE_A),
  .BASE_B  (BASE_B),
  .MAX_DATA(MAX_DATA),
  .ACK_HOLD(ACK_HOLD)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .ackOut (ackOut),
  .memWe  (memWe),
  .memAddr(memAddr),
  .done   (done)
);

// File: tb/byte_block_rx_bench.sv
`timescale 1ns/1ps
module byte_block_rx_bench;

  localparam int MAXD = 60;
  localparam int HOLD = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busData = 8'h00;
  logic       peerValid = 1'b0;
  logic       ackOut, memWe, done;
  logic [7:0] memAddr, memData;

  always #2.5 clk = ~clk;

  byte_block_rx u_byte_block_rx (
    .clk(clk), .rstN(rstN), .busData(busData), .peerValid(peerValid),
    .ackOut(ackOut), .memWe(memWe), .memAddr(memAddr), .memData(memData), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int wrCnt  = 0;
  logic [7:0] wrAddr [0:255];
  logic [7:0] wrData [0:255];
  logic [7:0] expData [0:255];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int expAddr(input int idx);
    return (idx % 2 == 0) ? (8'h31 + idx / 2) : (8'h61 + idx / 2);
  endfunction

  function automatic int expCount(input int len);
    return (len > MAXD) ? MAXD : len;
  endfunction

  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (wrCnt < 256) begin
        wrAddr[wrCnt] = memAddr;
        wrData[wrCnt] = memData;
      end
      wrCnt = wrCnt + 1;
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    peerValid = 1'b0;
    busData = 8'h00;
    repeat (3) @(negedge clk);
    check(ackOut == 0 && memWe == 0 && done == 0, "R1", "outputs in reset",
          {ackOut, memWe, done}, 0);
    wrCnt = 0;
    rstN = 1'b1;
    check(ackOut == 0, "R1", "ack first cycle", ackOut, 0);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check(ackOut == (k == 1), "R1", $sformatf("ready pulse cycle %0d", k), ackOut, (k == 1));
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit checkLat, input bit holdLong);
    int startWr;
    int waitCnt;
    int ackLen;
    busData = b;
    repeat ($urandom_range(0, 3)) @(negedge clk);
    startWr = wrCnt;
    peerValid = 1'b1;
    if (checkLat) begin
      for (int k = 1; k <= 3; k++) begin
        @(negedge clk);
        check(memWe == (k == 3), "R2", $sformatf("write latency edge %0d", k), memWe, (k == 3));
      end
    end
    waitCnt = 0;
    while (!ackOut && waitCnt < 60) begin
      @(negedge clk);
      waitCnt++;
    end
    check(ackOut == 1, "R5", "ack seen", ackOut, 1);
    if (!holdLong) peerValid = 1'b0;
    ackLen = 1;
    forever begin
      @(negedge clk);
      if (ackOut) ackLen++;
      else break;
    end
    check(ackLen == HOLD, "R5", "ack length", ackLen, HOLD);
    if (holdLong) begin
      repeat (20) @(negedge clk);
      #1;
      check(wrCnt == startWr + 1, "R3", "writes while valid held", wrCnt - startWr, 1);
      check(ackOut == 0, "R3", "no ack while valid held", ackOut, 0);
      peerValid = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic offerAfterDone(input logic [7:0] b);
    int startWr;
    bit sawAck;
    bit sawWe;
    busData = b;
    startWr = wrCnt;
    sawAck = 0;
    sawWe = 0;
    peerValid = 1'b1;
    repeat (15) begin
      @(negedge clk);
      if (ackOut) sawAck = 1;
      if (memWe) sawWe = 1;
    end
    peerValid = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(!sawAck && !sawWe && wrCnt == startWr, "R9", "quiet after done",
          {sawAck, sawWe}, 0);
    check(done == 1, "R9", "done stays high", done, 1);
  endtask

  task automatic runBlock(input int len, input int holdIdx);
    int n;
    doReset();
    n = expCount(len);
    sendByte(8'(len), 1'b1, 1'b0);
    for (int i = 0; i < n; i++) begin
      check(done == 0, "R9", "done low mid-block", done, 0);
      expData[i] = 8'($urandom);
      sendByte(expData[i], ($urandom_range(0, 3) == 0), (i == holdIdx));
    end
    check(done == 1, "R9", "done at final ack fall", done, 1);
    #1;
    check(wrCnt == n + 1, "R8", $sformatf("write count len=%0d", len), wrCnt, n + 1);
    check(wrAddr[0] == 8'h20 && wrData[0] == 8'(len), "R6", "length byte",
          {wrAddr[0], wrData[0]}, {8'h20, 8'(len)});
    for (int i = 0; i < n && i + 1 < wrCnt; i++) begin
      check(wrAddr[i + 1] == 8'(expAddr(i)), "R7", $sformatf("addr idx %0d", i),
            wrAddr[i + 1], expAddr(i));
      check(wrData[i + 1] == expData[i], "R4", $sformatf("data idx %0d", i),
            wrData[i + 1], expData[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    // directed corners: R8 zero, one, maximum, clamped lengths
    runBlock(0, -1);
    offerAfterDone(8'hA5);
    runBlock(1, -1);
    runBlock(MAXD, 7);
    runBlock(61, -1);
    offerAfterDone(8'h3C);
    runBlock(200, 0);
    offerAfterDone(8'hFF);
    // random blocks with an occasional held-valid byte (R3)
    for (int t = 0; t < 6; t++) begin
      int len;
      len = $urandom_range(2, MAXD);
      runBlock(len, $urandom_range(0, len - 1));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule